// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block watches two adjacent slots of an in-order pipeline. One slot holds the instruction that has just been fetched and is being decoded. The other holds the instruction that has been decoded and is about to execute. When the older instruction is a load, its data is not ready in time for the next instruction. If that younger instruction uses the ALU and reads the load's destination register, the detector raises a stall for one cycle. Forwarding cannot cover this case, because the loaded value arrives too late.

While the stall is high, the program counter and the fetch/decode latch keep their values and an all-zero bubble enters the decode/execute latch. On the next cycle the load has moved on and the stall drops by itself. A small latch-control wrapper is included so the detector can be exercised as part of a live pipeline. Each fetched word enters with three flags: is-load, uses-ALU and is-store. The flags travel with the word through the latches.

Register fields: bits 21..17 give source A, and bits 26..22 give both the second source of the younger instruction and the destination of the load.

Top module: `lu_stall_top`

## Requirements
- R1: The stall is low whenever the decode/execute slot does not hold a load.
- R2: The stall is low whenever the fetch/decode instruction does not use the ALU.
- R3: With a load in decode/execute and an ALU-using instruction in fetch/decode, the stall is high when fetch/decode bits 21..17 equal the load's bits 26..22, even if that instruction is a store.
- R4: With the same conditions, the stall is high when fetch/decode bits 26..22 equal the load's bits 26..22 and the younger instruction is not a store.
- R5: The second-source match of R4 raises no stall when the younger instruction is a store.
- R6: On the edge that ends a stall cycle, the program counter and the fetch/decode word hold their values.
- R7: On that same edge the decode/execute slot becomes all-zero, with its load flag cleared, so the stalled instruction does not advance.
- R8: The stall lasts exactly one cycle per hazard and drops without outside action. A new load that reaches decode/execute may raise a fresh stall.
- R9: On an edge with no stall, the program counter advances by 4, fetch/decode takes the fetched word and decode/execute takes the old fetch/decode word.
- R10: A synchronous active-low reset clears the program counter, both slots and therefore the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_instr | input | 32 | Instruction word fetched at the current program counter |
| if_is_load | input | 1 | Fetched word is a load |
| if_uses_alu | input | 1 | Fetched word uses the ALU |
| if_is_store | input | 1 | Fetched word is a store |
| pc_o | output | 32 | Program counter |
| stall_o | output | 1 | Load-use stall |
| fd_instr_o | output | 32 | Instruction in the fetch/decode slot |
| dx_instr_o | output | 32 | Instruction in the decode/execute slot |

## Verification
The stall comes straight from the latch contents through combinational logic, so it is valid in the same cycle that the consumer lands in fetch/decode. That is two edges after the load is placed on the fetch input. The hold, bubble and advance results of R6, R7 and R9 show up one edge after the cycle they depend on. Every check waits for the relevant rising edge and then samples 1 ns later, away from the edge. Expected program-counter values are counted in the bench from the number of edges without a stall since reset.

// File: rtl/lu_pkg.sv
// Shared widths, field positions and the pipeline slot type for the
// load-use stall block. Assumes a 32-bit word with 5-bit register fields.
package lu_pkg;
    parameter int XLEN     = 32;
    parameter int REG_AW   = 5;
    parameter int SRCA_LSB = 17;   // first source field
    parameter int SRCB_LSB = 22;   // second source of younger instruction
    parameter int DEST_LSB = 22;   // destination of a load
    parameter int PC_STEP  = 4;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic            is_load;
        logic            uses_alu;
        logic            is_store;
    } slot_t;
endpackage

// File: rtl/lu_field_pick.sv
// Pulls one register-index field out of an instruction word.
// Assumes LSB + REG_AW fits within the word.
module lu_field_pick
    import lu_pkg::*;
#(
    parameter int LSB = SRCA_LSB
) (
    input  logic [XLEN-1:0] word,
    output reg_idx_t        idx
);
    localparam int MSB = LSB + REG_AW - 1;

    // bits outside the field are not needed here
    logic unused_word;
    assign unused_word = ^{word[XLEN-1:MSB+1], word[LSB-1:0]};

    // field slice
    assign idx = word[MSB:LSB];
endmodule

// File: rtl/lu_hazard_detect.sv
// Combinational load-use detector. Raises stall when the decode/execute
// slot is a load and the fetch/decode slot uses the ALU and reads the
// load's destination. The second-source compare is ignored for stores.
// Assumes both slot flags are already decoded upstream.
module lu_hazard_detect
    import lu_pkg::*;
(
    input  slot_t fd_slot,
    input  slot_t dx_slot,
    output logic  stall
);
    reg_idx_t fd_srca, fd_srcb, dx_dest;
    logic     hit_a, hit_b;

    lu_field_pick #(.LSB(SRCA_LSB)) u_fd_a (.word(fd_slot.instr), .idx(fd_srca));
    lu_field_pick #(.LSB(SRCB_LSB)) u_fd_b (.word(fd_slot.instr), .idx(fd_srcb));
    lu_field_pick #(.LSB(DEST_LSB)) u_dx_d (.word(dx_slot.instr), .idx(dx_dest));

    // flags of each slot that this check does not look at
    logic unused_flags;
    assign unused_flags = ^{fd_slot.is_load, dx_slot.uses_alu, dx_slot.is_store};

    // register-match terms
    always_comb begin
        hit_a = (fd_srca == dx_dest);
        hit_b = (fd_srcb == dx_dest) && !fd_slot.is_store;
    end

    // final stall qualification
    assign stall = dx_slot.is_load && fd_slot.uses_alu && (hit_a || hit_b);
endmodule

// File: rtl/lu_pipe_ctrl.sv
// Program counter plus fetch/decode and decode/execute latches, steered
// by the stall. Assumes stall is a same-cycle function of these latches.
module lu_pipe_ctrl
    import lu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  slot_t           if_slot,
    input  logic            stall,
    output logic [XLEN-1:0] pc,
    output slot_t           fd_slot,
    output slot_t           dx_slot
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    // latch update: hold and insert a bubble on stall, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            fd_slot <= '0;
            dx_slot <= '0;
        end else if (stall) begin
            dx_slot <= '0;
        end else begin
            pc      <= pc + STEP;
            fd_slot <= if_slot;
            dx_slot <= fd_slot;
        end
    end

    AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dx_slot.is_load |-> !stall); // R1
    AST_NO_ALU_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fd_slot.uses_alu |-> !stall); // R2
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (pc == $past(pc)) && (fd_slot == $past(fd_slot))); // R6
    AST_BUBBLE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (dx_slot.instr == '0) && !dx_slot.is_load); // R7
    AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R8
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc == $past(pc) + STEP); // R9
endmodule

// File: rtl/lu_stall_top.sv
// Top of the load-use stall block: detector plus latch control.
// Assumes the fetched word arrives with its decoded flags.
module lu_stall_top
    import lu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] if_instr,
    input  logic        if_is_load,
    input  logic        if_uses_alu,
    input  logic        if_is_store,
    output logic [31:0] pc_o,
    output logic        stall_o,
    output logic [31:0] fd_instr_o,
    output logic [31:0] dx_instr_o
);
    slot_t if_slot, fd_slot, dx_slot;
    logic  stall;

    // pack the fetch inputs into a slot
    always_comb begin
        if_slot.instr    = if_instr;
        if_slot.is_load  = if_is_load;
        if_slot.uses_alu = if_uses_alu;
        if_slot.is_store = if_is_store;
    end

    lu_hazard_detect u_detect (
        .fd_slot (fd_slot),
        .dx_slot (dx_slot),
        .stall   (stall)
    );

    lu_pipe_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .if_slot (if_slot),
        .stall   (stall),
        .pc      (pc_o),
        .fd_slot (fd_slot),
        .dx_slot (dx_slot)
    );

    assign stall_o    = stall;
    assign fd_instr_o = fd_slot.instr;
    assign dx_instr_o = dx_slot.instr;
endmodule

// File: tb/lu_stall_top_tb.sv
module lu_stall_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] if_instr = '0;
    logic        if_is_load = 1'b0, if_uses_alu = 1'b0, if_is_store = 1'b0;
    logic [31:0] pc_o, fd_instr_o, dx_instr_o;
    logic        stall_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    lu_stall_top u_dut (
        .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .if_is_load(if_is_load),
        .if_uses_alu(if_uses_alu), .if_is_store(if_is_store), .pc_o(pc_o),
        .stall_o(stall_o), .fd_instr_o(fd_instr_o), .dx_instr_o(dx_instr_o)
    );

    // Vector: [67:36] older word, [35] older is load, [34:3] younger word,
    // [2] younger uses ALU, [1] younger is store, [0] expected stall.
    // Word layout: op[31:27], second source/dest[26:22], source A[21:17].
    localparam logic [67:0] VEC [9] = '{
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd1,5'd5,5'd3,17'd0, 1'b1,1'b0, 1'b1},  // R3
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd1,5'd3,5'd4,17'd0, 1'b1,1'b0, 1'b1},  // R4
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd6,5'd3,5'd4,17'd0, 1'b1,1'b1, 1'b0},  // R5
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd6,5'd3,5'd3,17'd0, 1'b1,1'b1, 1'b1},  // R3 store
        {5'd1,5'd3,5'd0,17'd0, 1'b0, 5'd1,5'd5,5'd3,17'd0, 1'b1,1'b0, 1'b0},  // R1
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd7,5'd3,5'd3,17'd0, 1'b0,1'b0, 1'b0},  // R2
        {5'd2,5'd3,5'd0,17'd0, 1'b1, 5'd1,5'd9,5'd7,17'd0, 1'b1,1'b0, 1'b0},  // R4 miss
        {5'd2,5'd0,5'd0,17'd0, 1'b1, 5'd1,5'd5,5'd0,17'd0, 1'b1,1'b0, 1'b1},  // R3 idx 0
        {5'd2,5'd31,5'd0,17'd0,1'b1, 5'd1,5'd31,5'd2,17'd0,1'b1,1'b0, 1'b1}   // R4 idx 31
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic feed(input logic [31:0] w, input logic ld, input logic alu,
                        input logic st);
        if_instr = w; if_is_load = ld; if_uses_alu = alu; if_is_store = st;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        feed('0, 1'b0, 1'b0, 1'b0);
        step();
        rst_n = 1'b1;
    endtask

    localparam logic [31:0] LD6  = {5'd2, 5'd6, 5'd0, 17'd0};
    localparam logic [31:0] USE6 = {5'd1, 5'd0, 5'd6, 17'd0};
    localparam logic [31:0] NXT  = {5'd1, 5'd1, 5'd1, 17'd5};
    localparam logic [31:0] LD2  = {5'd2, 5'd2, 5'd0, 17'd0};
    localparam logic [31:0] LD8  = {5'd2, 5'd8, 5'd2, 17'd0};
    localparam logic [31:0] USE8 = {5'd1, 5'd0, 5'd8, 17'd0};

    initial begin
        // R10: reset state
        do_reset();
        check(pc_o == 0, "R10 pc", pc_o, 0);
        check(fd_instr_o == 0 && dx_instr_o == 0, "R10 slots", fd_instr_o | dx_instr_o, 0);
        check(stall_o == 1'b0, "R10 stall", {31'd0, stall_o}, 0);

        // R9: plain advance without loads
        for (int i = 0; i < 3; i++) begin
            feed(32'h1000 + i, 1'b0, 1'b1, 1'b0);
            step();
        end
        check(pc_o == 12, "R9 pc", pc_o, 12);
        check(fd_instr_o == 32'h1002, "R9 fd", fd_instr_o, 32'h1002);
        check(dx_instr_o == 32'h1001, "R9 dx", dx_instr_o, 32'h1001);

        // table of detector vectors
        for (int k = 0; k < 9; k++) begin
            do_reset();
            feed(VEC[k][67:36], VEC[k][35], 1'b0, 1'b0);
            step();
            feed(VEC[k][34:3], 1'b0, VEC[k][2], VEC[k][1]);
            step();
            check(stall_o == VEC[k][0], $sformatf("vector %0d (R1..R5 table)", k),
                  {31'd0, stall_o}, {31'd0, VEC[k][0]});
        end

        // R6/R7/R8: full hazard sequence
        do_reset();
        feed(LD6, 1'b1, 1'b1, 1'b0);  step();
        feed(USE6, 1'b0, 1'b1, 1'b0); step();
        feed(NXT, 1'b0, 1'b0, 1'b0);
        check(stall_o == 1'b1, "R3 live stall", {31'd0, stall_o}, 1);
        check(pc_o == 8, "R9 pc before stall", pc_o, 8);
        step();
        check(pc_o == 8, "R6 pc hold", pc_o, 8);
        check(fd_instr_o == USE6, "R6 fd hold", fd_instr_o, USE6);
        check(dx_instr_o == 0, "R7 bubble", dx_instr_o, 0);
        check(stall_o == 1'b0, "R8 stall drops", {31'd0, stall_o}, 0);
        step();
        check(dx_instr_o == USE6, "R9 consumer advances", dx_instr_o, USE6);
        check(fd_instr_o == NXT && pc_o == 12, "R9 resume", pc_o, 12);

        // R8: back-to-back loads give two separate one-cycle stalls
        do_reset();
        feed(LD2, 1'b1, 1'b1, 1'b0);  step();
        feed(LD8, 1'b1, 1'b1, 1'b0);  step();
        feed(USE8, 1'b0, 1'b1, 1'b0);
        check(stall_o == 1'b1, "R8 first stall", {31'd0, stall_o}, 1);
        step();
        check(stall_o == 1'b0, "R8 gap", {31'd0, stall_o}, 0);
        step();
        check(dx_instr_o == LD8 && stall_o == 1'b1, "R8 second stall",
              {31'd0, stall_o}, 1);
        step();
        check(stall_o == 1'b0 && dx_instr_o == 0, "R8 second drop", dx_instr_o, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule